// File: doc/BRIEF.md
# Bitmask Dictionary Symbol Decompressor

This block expands a compressed configuration stream into 32-bit configuration words, in order, ready to be written one after another into configuration memory. Compressed data arrives one byte per handshake and collects in a bit buffer. Each code in the stream rebuilds one word, or a run of words, in one of four ways. A raw word is passed through unchanged. A dictionary index selects a stored word. A dictionary index can also come with a small positioned bitmask that flips a few bits of the stored word. A Golomb-coded count repeats the most recent word.

Software or a loader fills the dictionary through a plain write port before the stream starts. The port can also be written again while the stream is idle. Output words leave through a valid/ready interface. While the consumer holds ready low, the block waits and loses nothing.

Top module: `bitmask_decomp`

## Requirements
- R1: While reset is held, outValid and errFlag are low and inReady is high.
- R2: A byte is taken only on a cycle with inValid and inReady both high. Its bits join the code stream most significant bit first, after all earlier bytes, and a code may span bytes. inReady is low whenever more than 56 unread bits are buffered. So with outReady held low, at most 13 bytes are taken from an empty start.
- R3: Prefix bits 00 followed by 32 bits produce exactly those 32 bits as one output word, first bit as the most significant.
- R4: Prefix 01 followed by a 4-bit index produces the stored dictionary word at that index, unchanged. All 16 index values are valid.
- R5: Prefix 10 is followed by a 3-bit nibble position p, a 4-bit mask m and a 4-bit index. It produces the stored word at that index XOR (m shifted left by 4*p).
- R6: Prefix 11 is followed by q one-bits, a zero bit and a 2-bit remainder r, with q at most 15. It re-emits the most recently produced word 4*q+r+1 times.
- R7: A repeat code that arrives before any word has been produced raises errFlag for exactly one cycle. It is consumed and produces no word.
- R8: When outValid is high and outReady is low, outValid stays high and outData keeps its value on the next cycle.
- R9: Every word coded in the stream appears on the output exactly once per handshake, in code order, with no extra words.
- R10: A write with dictWe high stores dictData at dictAddr on that clock edge. Codes decoded afterwards use the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| dictWe | input | 1 | Dictionary write strobe |
| dictAddr | input | 4 | Dictionary write index |
| dictData | input | 32 | Dictionary write word |
| inValid | input | 1 | Compressed byte available |
| inData | input | 8 | Compressed byte, first stream bit in bit 7 |
| inReady | output | 1 | Buffer can take a byte this cycle |
| outValid | output | 1 | Output word valid |
| outData | output | 32 | Decompressed word |
| outReady | input | 1 | Consumer takes the word this cycle |
| errFlag | output | 1 | One-cycle pulse for a repeat code with no prior word |

## Verification
The bench places a repeat code first in the stream. A decoder that does not trap this case either emits a stray word or fails to skip the code's bits, and every later word then comes out shifted or garbled. Masks are placed at both the lowest and the highest nibble, with full and single-bit patterns. A wrong shift or a wrong field split shows up as a wrong word at that position. Repeat counts of one, of a mid-range value and of the longest quotient catch an off-by-one in the run length or in the unary scan, because either error changes the word count and breaks the ordering that follows. A long stall with input still offered shows whether the buffer overruns or keeps taking bytes it cannot hold. Throttled and stalled output catches a word that is dropped or changes while it waits.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

  typedef enum logic [1:0] {
    CODE_RAW  = 2'b00,
    CODE_DICT = 2'b01,
    CODE_MASK = 2'b10,
    CODE_RPT  = 2'b11
  } codeKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic consume;   // drop the current code from the bit buffer
    logic loadSym;   // load the decoded word into the output register
  } dpCtl_t;

endpackage

// File: rtl/bmd_datapath.sv
module bmd_datapath
  import bmd_pkg::*;
#(
  parameter int SYM_W   = 32,
  parameter int IDX_W   = 4,
  parameter int MASK_W  = 4,
  parameter int BUF_W   = 64,
  parameter int QUO_MAX = 15,
  parameter int REM_W   = 2,
  localparam int CNT_W  = $clog2(QUO_MAX + 1) + REM_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inData,
  output logic              inReady,
  input  logic              dictWe,
  input  logic [IDX_W-1:0]  dictAddr,
  input  logic [SYM_W-1:0]  dictData,
  input  dpCtl_t            ctl,
  output codeKind_t         codeKind,
  output logic              codeReady,
  output logic [CNT_W-1:0]  rptCount,
  output logic [SYM_W-1:0]  outData
);

  localparam int FILL_W = $clog2(BUF_W + 1);
  localparam int QUO_W  = $clog2(QUO_MAX + 1);
  localparam int POS_W  = $clog2(SYM_W / MASK_W);
  localparam int BODY_W = BUF_W - 2;
  localparam int DICT_N = 1 << IDX_W;
  localparam logic [FILL_W-1:0] LEN_RAW  = FILL_W'(2 + SYM_W);
  localparam logic [FILL_W-1:0] LEN_DICT = FILL_W'(2 + IDX_W);
  localparam logic [FILL_W-1:0] LEN_MASK = FILL_W'(2 + POS_W + MASK_W + IDX_W);
  localparam logic [FILL_W-1:0] LEN_RPT0 = FILL_W'(3 + REM_W);
  localparam logic [FILL_W-1:0] ROOM     = FILL_W'(BUF_W - 8);

  // bit buffer: next stream bit sits at the top, unused bits kept zero
  logic [BUF_W-1:0]  bitBuf;
  logic [FILL_W-1:0] fill;
  logic [BODY_W-1:0] body;
  codeKind_t         kind;

  assign body     = bitBuf[BODY_W-1:0];
  assign kind     = codeKind_t'(bitBuf[BUF_W-1 -: 2]);
  assign codeKind = kind;
  assign inReady  = (fill <= ROOM);

  // unary quotient scan
  logic [QUO_W-1:0] quo;
  logic             quoFound;
  always_comb begin
    quo      = '0;
    quoFound = 1'b0;
    for (int k = 0; k <= QUO_MAX; k++) begin
      if (!quoFound && !body[BODY_W-1-k]) begin
        quoFound = 1'b1;
        quo      = QUO_W'(k);
      end
    end
  end

  logic [REM_W-1:0] remBits;
  assign remBits  = REM_W'(body >> (BODY_W - REM_W - 1 - int'(quo)));
  assign rptCount = {quo, remBits};

  // code length per kind
  logic [FILL_W-1:0] codeLen;
  always_comb begin
    unique case (kind)
      CODE_RAW:  codeLen = LEN_RAW;
      CODE_DICT: codeLen = LEN_DICT;
      CODE_MASK: codeLen = LEN_MASK;
      default:   codeLen = LEN_RPT0 + FILL_W'(quo);
    endcase
  end
  assign codeReady = (fill >= codeLen) && ((kind != CODE_RPT) || quoFound);

  // dictionary
  logic [SYM_W-1:0] dict [DICT_N];
  always_ff @(posedge clk) begin
    if (dictWe) dict[dictAddr] <= dictData;
  end

  // field extraction
  logic [SYM_W-1:0]  rawSym;
  logic [IDX_W-1:0]  hitIdx;
  logic [POS_W-1:0]  mPos;
  logic [MASK_W-1:0] mVal;
  logic [IDX_W-1:0]  mIdx;
  logic [SYM_W-1:0]  maskWord;
  logic [SYM_W-1:0]  decSym;

  assign rawSym   = body[BODY_W-1 -: SYM_W];
  assign hitIdx   = body[BODY_W-1 -: IDX_W];
  assign mPos     = body[BODY_W-1 -: POS_W];
  assign mVal     = body[BODY_W-1-POS_W -: MASK_W];
  assign mIdx     = body[BODY_W-1-POS_W-MASK_W -: IDX_W];
  assign maskWord = SYM_W'(mVal) << (int'(mPos) * MASK_W);

  always_comb begin
    unique case (kind)
      CODE_RAW:  decSym = rawSym;
      CODE_DICT: decSym = dict[hitIdx];
      CODE_MASK: decSym = dict[mIdx] ^ maskWord;
      default:   decSym = outData;
    endcase
  end

  // buffer update: drop consumed code, append accepted byte behind the rest
  logic              take;
  logic [FILL_W-1:0] useLen;
  logic [FILL_W-1:0] remain;
  logic [BUF_W-1:0]  inPlaced;

  assign take     = inValid && inReady;
  assign useLen   = ctl.consume ? codeLen : '0;
  assign remain   = fill - useLen;
  assign inPlaced = {inData, {(BUF_W-8){1'b0}}} >> remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitBuf <= '0;
      fill   <= '0;
    end else begin
      bitBuf <= (bitBuf << useLen) | (take ? inPlaced : '0);
      fill   <= remain + (take ? FILL_W'(8) : '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           outData <= '0;
    else if (ctl.loadSym) outData <= decSym;
  end

endmodule

// File: rtl/bmd_ctrl.sv
module bmd_ctrl
  import bmd_pkg::*;
#(
  parameter int QUO_MAX = 15,
  parameter int REM_W   = 2,
  localparam int CNT_W  = $clog2(QUO_MAX + 1) + REM_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  codeKind_t        codeKind,
  input  logic             codeReady,
  input  logic [CNT_W-1:0] rptCount,
  input  logic             outReady,
  output dpCtl_t           ctl,
  output logic             outValid,
  output logic             errFlag
);

  typedef enum logic {ST_DECODE, ST_REPEAT} state_t;

  state_t           state;
  logic [CNT_W-1:0] rptLeft;
  logic             haveLast;
  logic             outFree;
  logic             emitAny;
  logic             errHit;
  logic             startRun;

  assign outFree = !outValid || outReady;

  always_comb begin
    ctl      = '0;
    emitAny  = 1'b0;
    errHit   = 1'b0;
    startRun = 1'b0;
    if (state == ST_DECODE) begin
      if (codeReady && outFree) begin
        ctl.consume = 1'b1;
        if (codeKind != CODE_RPT) begin
          ctl.loadSym = 1'b1;
          emitAny     = 1'b1;
        end else if (haveLast) begin
          emitAny  = 1'b1;
          startRun = (rptCount != '0);
        end else begin
          errHit = 1'b1;
        end
      end
    end else begin
      emitAny = outFree;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_DECODE;
      rptLeft  <= '0;
      haveLast <= 1'b0;
      outValid <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      errFlag  <= errHit;
      haveLast <= haveLast | ctl.loadSym;
      if (emitAny)       outValid <= 1'b1;
      else if (outReady) outValid <= 1'b0;
      if (state == ST_DECODE) begin
        if (startRun) begin
          state   <= ST_REPEAT;
          rptLeft <= rptCount;
        end
      end else if (emitAny) begin
        rptLeft <= rptLeft - CNT_W'(1);
        if (rptLeft == CNT_W'(1)) state <= ST_DECODE;
      end
    end
  end

endmodule

// File: rtl/bitmask_decomp.sv
module bitmask_decomp
  import bmd_pkg::*;
#(
  parameter int SYM_W   = 32,
  parameter int IDX_W   = 4,
  parameter int MASK_W  = 4,
  parameter int BUF_W   = 64,
  parameter int QUO_MAX = 15,
  parameter int REM_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dictWe,
  input  logic [IDX_W-1:0] dictAddr,
  input  logic [SYM_W-1:0] dictData,
  input  logic             inValid,
  input  logic [7:0]       inData,
  output logic             inReady,
  output logic             outValid,
  output logic [SYM_W-1:0] outData,
  input  logic             outReady,
  output logic             errFlag
);

  localparam int CNT_W = $clog2(QUO_MAX + 1) + REM_W;

  dpCtl_t           ctl;
  codeKind_t        codeKind;
  logic             codeReady;
  logic [CNT_W-1:0] rptCount;

  bmd_datapath #(
    .SYM_W(SYM_W), .IDX_W(IDX_W), .MASK_W(MASK_W),
    .BUF_W(BUF_W), .QUO_MAX(QUO_MAX), .REM_W(REM_W)
  ) dp (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .dictWe(dictWe), .dictAddr(dictAddr), .dictData(dictData),
    .ctl(ctl), .codeKind(codeKind), .codeReady(codeReady),
    .rptCount(rptCount), .outData(outData)
  );

  bmd_ctrl #(.QUO_MAX(QUO_MAX), .REM_W(REM_W)) ctrl (
    .clk(clk), .rstN(rstN),
    .codeKind(codeKind), .codeReady(codeReady), .rptCount(rptCount),
    .outReady(outReady), .ctl(ctl), .outValid(outValid), .errFlag(errFlag)
  );

endmodule

// File: rtl/bitmask_decomp_chk.sv
module bitmask_decomp_chk #(
  parameter int SYM_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             outValid,
  input logic             outReady,
  input logic             errFlag,
  input logic [SYM_W-1:0] outData
);

  logic seenValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenValid <= 1'b0;
    else       seenValid <= seenValid | outValid;
  end

  AST_STALL_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);                       // R8
  AST_STALL_DATA: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outData));               // R8
  AST_ERR_BEFORE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !seenValid);                                   // R7
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !outValid);                                    // R7

endmodule

bind bitmask_decomp bitmask_decomp_chk #(.SYM_W(SYM_W)) chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .errFlag(errFlag), .outData(outData)
);

// File: tb/bitmask_decomp_test.sv
`timescale 1ns/1ps
module bitmask_decomp_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dictWe, inValid, inReady, outValid, outReady, errFlag;
  logic [3:0]  dictAddr;
  logic [31:0] dictData, outData;
  logic [7:0]  inData;

  always #2.5 clk = ~clk;

  bitmask_decomp uut (
    .clk(clk), .rstN(rstN), .dictWe(dictWe), .dictAddr(dictAddr),
    .dictData(dictData), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData),
    .outReady(outReady), .errFlag(errFlag)
  );

  bit          bitQ[$];
  logic [7:0]  byteQ[$];
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] dictModel [16];
  logic [31:0] lastSym = '0;
  bit          haveLastM = 0;
  int expErr = 0, errSeen = 0, accepted = 0;
  int nChecks = 0, nFail = 0, readyMode = 0, cyc = 0;
  bit prevStall = 0, finished = 0;
  logic [31:0] prevData = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic putBits(input logic [31:0] v, input int n);
    for (int b = n - 1; b >= 0; b--) bitQ.push_back(v[b]);
  endtask

  task automatic pack();
    while (bitQ.size() >= 8) begin
      logic [7:0] by;
      for (int b = 7; b >= 0; b--) by[b] = bitQ.pop_front();
      byteQ.push_back(by);
    end
  endtask

  task automatic expectSym(input logic [31:0] s, input string tag);
    expQ.push_back(s);
    tagQ.push_back(tag);
    lastSym = s;
    haveLastM = 1;
  endtask

  task automatic encRaw(input logic [31:0] d);
    putBits(0, 2); putBits(d, 32); expectSym(d, "R3"); pack();
  endtask

  task automatic encDict(input int i, input string tag);
    putBits(1, 2); putBits(i, 4); expectSym(dictModel[i], tag); pack();
  endtask

  task automatic encMask(input int p, input int m, input int i, input string tag);
    putBits(2, 2); putBits(p, 3); putBits(m, 4); putBits(i, 4);
    expectSym(dictModel[i] ^ (32'(m) << (p * 4)), tag); pack();
  endtask

  task automatic encRpt(input int cnt);
    putBits(3, 2);
    for (int k = 0; k < cnt / 4; k++) bitQ.push_back(1'b1);
    bitQ.push_back(1'b0);
    putBits(cnt % 4, 2);
    if (haveLastM) begin
      for (int k = 0; k <= cnt; k++) begin
        expQ.push_back(lastSym);
        tagQ.push_back("R6");
      end
    end else expErr++;
    pack();
  endtask

  // close the stream on a byte boundary with a repeat code of fitting length
  task automatic align();
    int need;
    need = (8 - (bitQ.size() % 8)) % 8;
    if (need != 0) encRpt(((need + 3) % 8) * 4);
    pack();
  endtask

  task automatic waitDrain();
    int guard;
    guard = 0;
    while ((byteQ.size() != 0 || expQ.size() != 0) && guard < 50000) begin
      @(posedge clk); guard++;
    end
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic writeDict(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    dictWe = 1'b1; dictAddr = 4'(a); dictData = d; dictModel[a] = d;
    @(posedge clk); #1;
    dictWe = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  // byte feeder and output-ready pattern
  initial begin
    inValid = 1'b0; inData = '0; outReady = 1'b0;
    forever begin
      @(posedge clk);
      cyc++;
      if (inValid && inReady) begin
        void'(byteQ.pop_front());
        accepted++;
      end
      #1;
      inValid = (byteQ.size() > 0);
      inData  = inValid ? byteQ[0] : 8'h00;
      case (readyMode)
        0:       outReady = 1'b1;
        1:       outReady = ((cyc * 7) % 5) < 3;
        default: outReady = 1'b0;
      endcase
    end
  end

  // per-cycle comparison against the expected word queue
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall)
        check(outValid && (outData == prevData), "R8", outData, prevData);
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(1'b0, "R9", outData, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(outData == e, t, outData, e);
        end
      end
      if (errFlag) errSeen++;
      prevStall = outValid && !outReady;
      prevData  = outData;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL R9: watchdog expired, actual=%0d pending expected=0", expQ.size());
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    int base;
    dictWe = 1'b0; dictAddr = '0; dictData = '0;
    repeat (3) @(posedge clk);
    #1;
    check(outValid == 1'b0, "R1", 32'(outValid), 32'h0);
    check(errFlag == 1'b0, "R1", 32'(errFlag), 32'h0);
    check(inReady == 1'b1, "R1", 32'(inReady), 32'h1);
    @(posedge clk); #1;
    rstN = 1'b1;

    for (int k = 0; k < 16; k++)
      writeDict(k, (32'h9E37_79B9 * 32'(k + 1)) ^ {4'(k), 28'h0C3_5A69});

    // phase 1: directed codes, output always ready
    readyMode = 0;
    encRpt(5);                       // R7: repeat with no prior word
    encRaw(32'hA5A5_0F0F);
    encDict(0, "R4");
    encDict(15, "R4");
    encMask(0, 4'hF, 3, "R5");
    encMask(7, 4'h9, 15, "R5");
    encRpt(0);
    encDict(7, "R4");
    encRpt(9);
    encRaw(32'h0000_0001);
    encRpt(63);
    encMask(3, 4'h1, 5, "R5");
    align();
    waitDrain();
    check(errSeen == 1, "R7", 32'(errSeen), 32'h1);

    // phase 2: mixed codes, throttled output
    readyMode = 1;
    seed = 32'h1234_5678;
    for (int n = 0; n < 40; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      case (seed[17:16])
        2'd0: encRaw(seed ^ 32'hF0E1_D2C3);
        2'd1: encDict(int'(seed[23:20]), "R4");
        2'd2: encMask(int'(seed[26:24]), int'(seed[31:28]), int'(seed[23:20]), "R5");
        default: encRpt(int'(seed[30:20]) % 20);
      endcase
    end
    align();
    waitDrain();

    // phase 3: output stalled, input must back off (R2)
    readyMode = 2;
    base = accepted;
    for (int n = 0; n < 20; n++) encRaw(32'h0101_0101 * 32'(n + 1));
    align();
    repeat (100) @(posedge clk);
    #1;
    check((accepted - base) >= 8 && (accepted - base) <= 13, "R2",
          32'(accepted - base), 32'd13);
    readyMode = 0;
    waitDrain();

    // phase 4: dictionary rewrite between streams (R10)
    writeDict(5, 32'hDEAD_BEEF);
    encDict(5, "R10");
    encMask(1, 4'h6, 5, "R10");
    encRpt(3);
    align();
    waitDrain();

    check(expQ.size() == 0, "R9", 32'(expQ.size()), 32'h0);
    check(errSeen == expErr, "R7", 32'(errSeen), 32'(expErr));
    check(byteQ.size() == 0, "R2", 32'(byteQ.size()), 32'h0);
    finished = 1;
    summary();
    $finish;
  end

endmodule